// File: doc/BRIEF.md
# Byte-Accessed Modulo Timer Counter

This block is a 16-bit up-counter with a programmable wrap limit. Software reaches it over an 8-bit register bus as high and low byte halves. The counter advances on each clock in which the count-enable input `cnt_tick` is high, which stands in for a prescaler tick. When it reaches the modulo limit, the next advance returns it to zero and raises an overflow flag. The flag drives a level interrupt request when the interrupt enable bit is set.

Two rules keep the byte-wide access coherent:
- **Counter reads.** Reading the counter's high byte captures the low byte into a holding register. A later low-byte read then returns the half that belongs with the high byte already read. This holds across a debug halt.
- **Limit writes.** Writing the limit's high byte blocks overflow flagging until the low byte arrives. A half-updated limit therefore cannot raise a false overflow.

The register bus is a plain strobe interface with no back-pressure. A read is answered in the same cycle the strobe is high, and `reg_rdata` is zero otherwise. Register side effects take place at the clock edge that ends the strobe cycle.

Top module: `bmt_timer`

## Requirements
- R1: After reset:
  - the counter reads 0x0000 and the modulo limit reads 0xFFFF;
  - the control/status byte at offset 0x10 reads 0x00;
  - `irq` is low.
- R2: The counter advances by one at each clock edge where `cnt_tick` is high, `dbg_halt` is low and the stop bit (offset 0x10, bit 5) is clear. With the stop bit set or `dbg_halt` high, the count holds its value without clearing.
- R3: On an advancing edge with the count equal to the limit, the count becomes 0x0000 and the overflow flag (offset 0x10, bit 7) is set.
- R4: A read of the counter high byte (offset 0x12) returns the live high byte. If no capture is pending, it also captures the live low byte. Further high-byte reads leave a pending capture unchanged.
- R5: A read of the counter low byte (offset 0x13) returns the captured byte when a capture is pending and the live low byte otherwise. It ends any pending capture.
- R6: A capture made while `dbg_halt` is high stays pending after the halt ends, until the low byte is read.
- R7: Writing 1 to bit 4 of offset 0x10 clears the counter at the following clock edge. Bit 4 always reads 0.
- R8: A write to the limit high byte (offset 0x14) keeps the overflow flag from setting until the limit low byte (offset 0x15) is written. The counter still wraps during that window.
- R9: To clear the overflow flag, read offset 0x10 while the flag is set, then write offset 0x10 with bit 7 at 0. If a wrap happens at the same edge as that write, the flag stays set.
- R10: `irq` is high exactly while the overflow flag and the interrupt enable bit (offset 0x10, bit 6) are both set, and it stays high until the flag is cleared.
- R11: Writes to offsets 0x12 and 0x13 have no effect on the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_tick | input | 1 | Count enable (prescaler tick) |
| dbg_halt | input | 1 | Debug halt; freezes counting |
| reg_addr | input | 8 | Register offset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid in the strobe cycle |
| irq | output | 1 | Overflow interrupt request (level) |

## Verification
The bench targets the following corner cases, and each one catches a specific wrong design:
- **Repeated high-byte read.** The bench reads the high byte twice with counting in between. A design that recaptures on every high-byte read returns a newer low byte.
- **Capture across a debug halt.** The bench makes a capture during the halt and resumes counting before reading the low byte. A design that drops the capture when the halt ends returns the live byte.
- **Wrap during a half-written limit.** The bench lets the counter wrap while the limit update is incomplete. A design without the write guard raises the flag there.
- **Flag clear at the same edge as a wrap.** The bench lands the clearing write on the wrapping edge. A design where clearing has priority loses the overflow.
- **Control byte under stop and halt.** Stop, halt and counter reset are exercised against the count.

// File: rtl/bmt_pkg.sv
package bmt_pkg;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_CNT_HI = 8'h12;
  localparam logic [ADDR_W-1:0] OFS_CNT_LO = 8'h13;
  localparam logic [ADDR_W-1:0] OFS_MOD_HI = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_MOD_LO = 8'h15;
  // control/status bit positions
  localparam int B_FLAG = 7;
  localparam int B_IE   = 6;
  localparam int B_STOP = 5;
  localparam int B_TRST = 4;
endpackage

// File: rtl/bmt_regs.sv
module bmt_regs
  import bmt_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              wrap,
  output logic [CNT_W-1:0]  mod_q,
  output logic              ie_q,
  output logic              stop_q,
  output logic              trst_q,
  output logic              flag_q,
  output logic              inhibit_q
);
  logic ctrl_wr, ctrl_rd, arm_q, flag_clr, flag_set;

  assign ctrl_wr  = wr_en && (addr == OFS_CTRL);
  assign ctrl_rd  = rd_en && (addr == OFS_CTRL);
  assign flag_clr = ctrl_wr && !wdata[B_FLAG] && arm_q;
  assign flag_set = wrap && !inhibit_q;

  // limit register, one generated byte lane per half
  for (genvar h = 0; h < 2; h++) begin : g_lane
    localparam logic [ADDR_W-1:0] LANE_OFS = (h == 1) ? OFS_MOD_HI : OFS_MOD_LO;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mod_q[h*BYTE_W +: BYTE_W] <= '1;
      else if (wr_en && (addr == LANE_OFS)) mod_q[h*BYTE_W +: BYTE_W] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q      <= 1'b0;
      stop_q    <= 1'b0;
      trst_q    <= 1'b0;
      flag_q    <= 1'b0;
      arm_q     <= 1'b0;
      inhibit_q <= 1'b0;
    end else begin
      trst_q <= ctrl_wr && wdata[B_TRST];
      if (ctrl_wr) begin
        ie_q   <= wdata[B_IE];
        stop_q <= wdata[B_STOP];
      end
      if (flag_set)      flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
      if (ctrl_wr)                arm_q <= 1'b0;
      else if (ctrl_rd && flag_q) arm_q <= 1'b1;
      if (wr_en && addr == OFS_MOD_HI)      inhibit_q <= 1'b1;
      else if (wr_en && addr == OFS_MOD_LO) inhibit_q <= 1'b0;
    end
  end
endmodule

// File: rtl/bmt_counter.sv
module bmt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             clr,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] count_q,
  output logic             wrap
);
  assign wrap = adv && (count_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count_q <= '0;
    else if (clr)  count_q <= '0;
    else if (wrap) count_q <= '0;
    else if (adv)  count_q <= count_q + 1'b1;
  end
endmodule

// File: rtl/bmt_snap.sv
module bmt_snap #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_hi,
  input  logic              rd_lo,
  input  logic [BYTE_W-1:0] live_lo,
  output logic              held_q,
  output logic [BYTE_W-1:0] snap_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      snap_q <= '0;
    end else if (rd_lo) begin
      held_q <= 1'b0;
    end else if (rd_hi && !held_q) begin
      held_q <= 1'b1;
      snap_q <= live_lo;
    end
  end
endmodule

// File: rtl/bmt_timer.sv
module bmt_timer
  import bmt_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_tick,
  input  logic              dbg_halt,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic              irq
);
  localparam int CNT_W = 2 * BYTE_W;

  logic [CNT_W-1:0]  mod_q, count_q;
  logic [BYTE_W-1:0] snap_q;
  logic ie_q, stop_q, trst_q, flag_q, inhibit_q, held_q, wrap, adv;
  logic rd_hi, rd_lo;

  assign adv   = cnt_tick && !dbg_halt && !stop_q && !trst_q;
  assign rd_hi = reg_rd && (reg_addr == OFS_CNT_HI);
  assign rd_lo = reg_rd && (reg_addr == OFS_CNT_LO);

  bmt_regs #(.BYTE_W(BYTE_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .rd_en(reg_rd),
    .addr(reg_addr), .wdata(reg_wdata), .wrap(wrap),
    .mod_q(mod_q), .ie_q(ie_q), .stop_q(stop_q), .trst_q(trst_q),
    .flag_q(flag_q), .inhibit_q(inhibit_q)
  );

  bmt_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .adv(adv), .clr(trst_q),
    .limit(mod_q), .count_q(count_q), .wrap(wrap)
  );

  bmt_snap #(.BYTE_W(BYTE_W)) snap_i (
    .clk(clk), .rst_n(rst_n), .rd_hi(rd_hi), .rd_lo(rd_lo),
    .live_lo(count_q[BYTE_W-1:0]), .held_q(held_q), .snap_q(snap_q)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      unique case (reg_addr)
        OFS_CTRL: begin
          reg_rdata[B_FLAG] = flag_q;
          reg_rdata[B_IE]   = ie_q;
          reg_rdata[B_STOP] = stop_q;
        end
        OFS_CNT_HI: reg_rdata = count_q[CNT_W-1:BYTE_W];
        OFS_CNT_LO: reg_rdata = held_q ? snap_q : count_q[BYTE_W-1:0];
        OFS_MOD_HI: reg_rdata = mod_q[CNT_W-1:BYTE_W];
        OFS_MOD_LO: reg_rdata = mod_q[BYTE_W-1:0];
        default:    reg_rdata = '0;
      endcase
    end
  end

  assign irq = flag_q && ie_q;
endmodule

// File: rtl/bmt_timer_chk.sv
module bmt_timer_chk
  import bmt_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cnt_tick,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [BYTE_W-1:0] reg_wdata,
  input logic              irq,
  input logic [CNT_W-1:0]  count_q,
  input logic              flag_q,
  input logic              inhibit_q,
  input logic              trst_q,
  input logic              held_q
);
  // R2
  hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_tick && !trst_q) |=> $stable(count_q));

  // R7
  trst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFS_CTRL && reg_wdata[B_TRST]) |=> ##1 (count_q == '0));

  // R8
  inhibit_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit_q && !flag_q) |=> !flag_q);

  // R5
  lo_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == OFS_CNT_LO) |=> !held_q);

  // R4
  capture_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && !(reg_rd && reg_addr == OFS_CNT_LO)) |=> held_q);

  // R10
  irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(reg_wr && reg_addr == OFS_CTRL)) |=> irq);
endmodule

bind bmt_timer bmt_timer_chk #(.BYTE_W(BYTE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .reg_addr(reg_addr),
  .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata), .irq(irq),
  .count_q(count_q), .flag_q(flag_q), .inhibit_q(inhibit_q),
  .trst_q(trst_q), .held_q(held_q)
);

// File: tb/bmt_timer_tb_top.sv
`timescale 1ns/100ps
module bmt_timer_tb_top;
  import bmt_pkg::*;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, halt = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [7:0] addr = '0, wd = '0;
  logic [7:0] rdata;
  logic irq;
  int errs = 0, checks = 0;

  always #2 clk = ~clk;  // 250 MHz

  bmt_timer dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_tick(tick), .dbg_halt(halt),
    .reg_addr(addr), .reg_wr(wr), .reg_rd(rd), .reg_wdata(wd),
    .reg_rdata(rdata), .irq(irq)
  );

  // ---------------- behavioural reference model ----------------
  int m_cnt = 0, m_mod = 65535, m_snap = 0;
  bit m_flag = 0, m_ie = 0, m_stop = 0, m_trst = 0, m_inh = 0, m_arm = 0, m_held = 0;

  function automatic int m_read(input logic r, input logic [7:0] a);
    if (!r) return 0;
    case (a)
      8'h10: return (m_flag ? 128 : 0) + (m_ie ? 64 : 0) + (m_stop ? 32 : 0);
      8'h12: return m_cnt / 256;
      8'h13: return m_held ? m_snap : m_cnt % 256;
      8'h14: return m_mod / 256;
      8'h15: return m_mod % 256;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_mod = 65535; m_snap = 0;
      m_flag = 0; m_ie = 0; m_stop = 0; m_trst = 0; m_inh = 0; m_arm = 0; m_held = 0;
    end else begin
      bit adv, wrp, cwr, trst_n;
      adv = tick && !halt && !m_stop && !m_trst;
      wrp = adv && (m_cnt == m_mod);
      cwr = wr && addr == 8'h10;
      trst_n = cwr && wd[4];
      if (rd && addr == 8'h13) m_held = 0;
      else if (rd && addr == 8'h12 && !m_held) begin m_held = 1; m_snap = m_cnt % 256; end
      if (wrp && !m_inh) m_flag = 1;
      else if (cwr && !wd[7] && m_arm) m_flag = 0;
      if (cwr) m_arm = 0;
      else if (rd && addr == 8'h10 && m_flag) m_arm = 1;
      if (m_trst || wrp) m_cnt = 0;
      else if (adv) m_cnt = m_cnt + 1;
      if (cwr) begin m_ie = wd[6]; m_stop = wd[5]; end
      m_trst = trst_n;
      if (wr && addr == 8'h14) begin m_inh = 1; m_mod = (m_mod % 256) + wd * 256; end
      if (wr && addr == 8'h15) begin m_inh = 0; m_mod = (m_mod / 256) * 256 + wd; end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [7:0] a);
    case (a)
      8'h10: return "R9 ctrl read (model)";
      8'h12: return "R4 count high (model)";
      8'h13: return "R5 count low (model)";
      default: return "R8 limit read (model)";
    endcase
  endfunction

  // per-cycle comparison against the model, away from the clock edge
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      chk("R10 irq (model)", int'(irq), int'(m_flag && m_ie));
      chk(tag_of(addr), int'(rdata), m_read(rd, addr));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step(input logic w, input logic r, input logic [7:0] a,
                      input logic [7:0] d, input logic t, input logic h);
    @(negedge clk);
    wr = w; rd = r; addr = a; wd = d; tick = t; halt = h;
  endtask

  task automatic idle(input int n, input logic t);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 8'h00, 8'h00, t, 1'b0);
  endtask

  task automatic wreg(input logic [7:0] a, input logic [7:0] d);
    step(1'b1, 1'b0, a, d, 1'b0, 1'b0);
  endtask

  task automatic rreg(input logic [7:0] a, input int exp, input string tag,
                      input logic t = 1'b0, input logic h = 1'b0);
    step(1'b0, 1'b1, a, 8'h00, t, h);
    #1 chk(tag, int'(rdata), exp);
  endtask

  task automatic irq_chk(input bit exp, input string tag);
    idle(1, 1'b0);
    #1 chk(tag, int'(irq), int'(exp));
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    #800000;
    errs++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rreg(8'h12, 8'h00, "R1 count high");
    rreg(8'h13, 8'h00, "R1 count low");
    rreg(8'h14, 8'hFF, "R1 limit high");
    rreg(8'h15, 8'hFF, "R1 limit low");
    rreg(8'h10, 8'h00, "R1 ctrl");
    irq_chk(1'b0, "R1 irq");
    // R2 counting, stop and halt
    wreg(8'h10, 8'h10); idle(1, 1'b0);
    idle(10, 1'b1);
    rreg(8'h12, 8'h00, "R2 count high");
    rreg(8'h13, 10, "R2 count low");
    wreg(8'h10, 8'h20); idle(5, 1'b1);
    rreg(8'h13, 10, "R2 stop holds");
    wreg(8'h10, 8'h00);
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 1'b1);
    rreg(8'h13, 10, "R2 halt holds");
    // R4 capture survives a second high read
    rreg(8'h12, 8'h00, "R4 first high", 1'b1);
    idle(3, 1'b1);
    rreg(8'h12, 8'h00, "R4 second high", 1'b1);
    rreg(8'h13, 10, "R4 captured low");
    rreg(8'h13, 15, "R5 released live low");
    // R6 capture across halt
    rreg(8'h12, 8'h00, "R6 high in halt", 1'b1, 1'b1);
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 1'b1);
    idle(4, 1'b1);
    rreg(8'h13, 15, "R6 stale low kept");
    rreg(8'h13, 19, "R5 live after release");
    // R3 wrap and R10 interrupt
    wreg(8'h14, 8'h00); wreg(8'h15, 20); wreg(8'h10, 8'h40);
    idle(2, 1'b1);
    irq_chk(1'b1, "R10 irq raised");
    idle(3, 1'b0);
    irq_chk(1'b1, "R10 irq held");
    rreg(8'h10, 8'hC0, "R3 flag set");
    rreg(8'h13, 8'h00, "R3 count wrapped");
    wreg(8'h10, 8'h40);
    irq_chk(1'b0, "R9 irq cleared");
    rreg(8'h10, 8'h40, "R9 flag cleared");
    // R9 set wins over clear
    idle(21, 1'b1); idle(20, 1'b1);
    rreg(8'h10, 8'hC0, "R9 armed");
    step(1'b1, 1'b0, 8'h10, 8'h40, 1'b1, 1'b0);
    rreg(8'h10, 8'hC0, "R9 set wins");
    wreg(8'h10, 8'h40);
    rreg(8'h10, 8'h40, "R9 cleared after");
    // R8 inhibit during half-written limit
    wreg(8'h14, 8'h00);
    idle(21, 1'b1);
    rreg(8'h10, 8'h40, "R8 no flag while inhibited");
    rreg(8'h13, 8'h00, "R8 still wrapped");
    wreg(8'h15, 20);
    idle(21, 1'b1);
    rreg(8'h10, 8'hC0, "R8 flag after low write");
    wreg(8'h10, 8'h40);
    // R7 counter reset bit
    idle(7, 1'b1);
    wreg(8'h10, 8'h50); idle(1, 1'b0);
    rreg(8'h13, 8'h00, "R7 count cleared");
    rreg(8'h10, 8'h40, "R7 bit reads zero");
    // R11 counter bytes are read-only
    idle(3, 1'b1);
    wreg(8'h12, 8'hAA); wreg(8'h13, 8'h55);
    rreg(8'h12, 8'h00, "R11 high unchanged");
    rreg(8'h13, 3, "R11 low unchanged");
    idle(2, 1'b0);
    summary();
  end
endmodule